// File: doc/BRIEF.md
# Bus-Master-Aware Processor Idle State Controller

This block tracks which processor idle state the system is in (C0, C2, C3 or C4) and decides what bus master traffic does to it. Software asks for a deep state (C3 or C4) from C0. While the system is deep, a bus master request either wakes it fully to C0 or lifts it only as far as C2. In C2 the bus master arbiter is enabled so memory traffic can proceed. Once the requests stop, the block can drop back to the deep state it came from. Break events always return the system to C0.

An 8-bit configuration register holds the control bits. It also holds a scratch bit that software may use freely. A sticky bus master status flag records request activity, and software clears it by writing 1. One control bit keeps PCI, PCI Express and internal masters from setting the flag. Requests from LPC DMA and LPC masters still set it.

Top module: `bm_cstate_ctrl`

## Requirements
- R1: The configuration register resets to 00h. Bit 7 (scratch), bit 4 (popdown enable), bit 3 (popup enable) and bit 2 (status suppress) are read/write. Bits 6:5 and 1:0 ignore writes and read 0.
- R2: In C0, a sleep request enters C3 when `sleep_to_c4` is 0 and C4 when it is 1. The state encoding is C0=00, C2=01, C3=10, C4=11. In C3 and C4, `bm_en` is low.
- R3: With popup enable at 0, any bus master request seen in C3 or C4 returns the state to C0 on the next cycle.
- R4: With popup enable at 1, a bus master request seen in C3 or C4 moves the state to C2 on the next cycle with `bm_en` high.
- R5: In a C2 reached by popup, the state stays in C2 while any request is pending. If popdown and popup enable are both 1 and no request is pending, it returns to the remembered C3 or C4.
- R6: With popup enable at 0, the popdown enable bit has no effect: a C2 state is held even when no request is pending.
- R7: A break event returns the state to C0 from C2, C3 or C4 on the next cycle, with `bm_en` high. It takes priority over a bus master request in the same cycle.
- R8: With status suppress at 0, a request from PCI (`bm_req` bit 0), PCI Express (bit 1) or an internal master (bit 2) sets `bm_sts`.
- R9: With status suppress at 1, requests on bits 0 to 2 leave `bm_sts` clear. A request on bit 3 (LPC DMA or LPC master) still sets it.
- R10: Setting status suppress does not clear a `bm_sts` that is already set.
- R11: A pulse on `sts_clr` clears `bm_sts`. When a set condition and a clear arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Configuration register readback |
| sleep_req | input | 1 | Software request for a deep state (acted on in C0 only) |
| sleep_to_c4 | input | 1 | Deep target: 0 = C3, 1 = C4 |
| brk_evt | input | 1 | Break event other than bus master traffic |
| bm_req | input | NSRC | Bus master requests: bit0 PCI, bit1 PCIe, bit2 internal, bit3 LPC |
| sts_clr | input | 1 | Software write of 1 to the status flag |
| cstate | output | 2 | Current idle state (00 C0, 01 C2, 10 C3, 11 C4) |
| bm_en | output | 1 | Bus master arbiter enable |
| bm_sts | output | 1 | Sticky bus master activity flag |

## Verification
Deep-state entry is followed by a request with popup disabled, which must wake the system to C0. The same request with popup enabled must stop at C2, so the two paths are told apart. With popup on, requests that are held and then released show whether popdown waits for the traffic to end and returns to the remembered state rather than a fixed one. Clearing popup enable while in C2 shows that popdown is gated. Each request source is tried with suppression on and off to separate LPC traffic from the others. A set and a clear in the same cycle exposes the priority of the status flag.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        CS_C0 = 2'b00,
        CS_C2 = 2'b01,
        CS_C3 = 2'b10,
        CS_C4 = 2'b11
    } cstate_e;

    localparam int CFG_W      = 8;
    localparam int BIT_SCR    = 7;
    localparam int BIT_PDOWN  = 4;
    localparam int BIT_PUP    = 3;
    localparam int BIT_SUPP   = 2;
    localparam logic [CFG_W-1:0] CFG_WMASK =
        (CFG_W'(1) << BIT_SCR) | (CFG_W'(1) << BIT_PDOWN) |
        (CFG_W'(1) << BIT_PUP) | (CFG_W'(1) << BIT_SUPP);

    typedef struct packed {
        logic pdown_en;
        logic pup_en;
        logic supp_en;
    } ctl_t;

    function automatic logic is_deep(cstate_e s);
        return (s == CS_C3) || (s == CS_C4);
    endfunction

    function automatic logic arb_on(cstate_e s);
        return (s == CS_C0) || (s == CS_C2);
    endfunction

endpackage

// File: rtl/bmc_cfg_reg.sv
module bmc_cfg_reg
    import bmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output ctl_t             ctl
);
    logic [CFG_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data & CFG_WMASK;
    end

    assign rd_data      = q;
    assign ctl.pdown_en = q[BIT_PDOWN];
    assign ctl.pup_en   = q[BIT_PUP];
    assign ctl.supp_en  = q[BIT_SUPP];
endmodule

// File: rtl/bmc_sts_track.sv
module bmc_sts_track #(
    parameter int               NSRC     = 4,
    parameter logic [NSRC-1:0]  LPC_MASK = 4'b1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] bm_req,
    input  logic            supp_en,
    input  logic            clr,
    output logic            sts
);
    logic hit_lpc, hit_other, set_c;

    assign hit_lpc   = |(bm_req & LPC_MASK);
    assign hit_other = |(bm_req & ~LPC_MASK);
    assign set_c     = hit_lpc | (hit_other & ~supp_en);

    always_ff @(posedge clk) begin
        if (rst)        sts <= 1'b0;
        else if (set_c) sts <= 1'b1;
        else if (clr)   sts <= 1'b0;
    end
endmodule

// File: rtl/bmc_state_fsm.sv
module bmc_state_fsm
    import bmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sleep_req,
    input  logic    sleep_to_c4,
    input  logic    brk_evt,
    input  logic    bm_any,
    input  ctl_t    ctl,
    output cstate_e state,
    output logic    bm_en
);
    cstate_e st_q, st_n, deep_q, deep_n;
    logic    bm_en_q;

    always_comb begin
        st_n   = st_q;
        deep_n = deep_q;
        if (brk_evt) begin
            st_n   = CS_C0;
            deep_n = CS_C0;
        end else begin
            case (st_q)
                CS_C0: if (sleep_req) begin
                    st_n   = sleep_to_c4 ? CS_C4 : CS_C3;
                    deep_n = st_n;
                end
                CS_C3, CS_C4: if (bm_any) begin
                    if (ctl.pup_en) begin
                        st_n = CS_C2;
                    end else begin
                        st_n   = CS_C0;
                        deep_n = CS_C0;
                    end
                end
                CS_C2: if (ctl.pup_en && ctl.pdown_en && !bm_any && is_deep(deep_q))
                    st_n = deep_q;
                default: st_n = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CS_C0;
            deep_q  <= CS_C0;
            bm_en_q <= 1'b1;
        end else begin
            st_q    <= st_n;
            deep_q  <= deep_n;
            bm_en_q <= arb_on(st_n);
        end
    end

    assign state = st_q;
    assign bm_en = bm_en_q;
endmodule

// File: rtl/bm_cstate_ctrl.sv
module bm_cstate_ctrl
    import bmc_pkg::*;
#(
    parameter int              NSRC     = 4,
    parameter logic [NSRC-1:0] LPC_MASK = 4'b1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             sleep_req,
    input  logic             sleep_to_c4,
    input  logic             brk_evt,
    input  logic [NSRC-1:0]  bm_req,
    input  logic             sts_clr,
    output logic [1:0]       cstate,
    output logic             bm_en,
    output logic             bm_sts
);
    ctl_t    ctl;
    cstate_e state;

    bmc_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
        .rd_data(cfg_rd_data), .ctl(ctl)
    );

    bmc_sts_track #(.NSRC(NSRC), .LPC_MASK(LPC_MASK)) u_sts (
        .clk(clk), .rst(rst), .bm_req(bm_req), .supp_en(ctl.supp_en),
        .clr(sts_clr), .sts(bm_sts)
    );

    bmc_state_fsm u_fsm (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_to_c4(sleep_to_c4),
        .brk_evt(brk_evt), .bm_any(|bm_req), .ctl(ctl),
        .state(state), .bm_en(bm_en)
    );

    assign cstate = state;
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
    parameter int              NSRC     = 4,
    parameter logic [NSRC-1:0] LPC_MASK = 4'b1000
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      cfg_rd_data,
    input logic            sleep_req,
    input logic            brk_evt,
    input logic [NSRC-1:0] bm_req,
    input logic            sts_clr,
    input logic [1:0]      cstate,
    input logic            bm_en,
    input logic            bm_sts
);
    logic pup;
    assign pup = cfg_rd_data[3];

    assert_enter_deep_R2: assert property (@(posedge clk) disable iff (rst)
        (cstate == 2'b00 && sleep_req && !brk_evt) |=> (cstate[1] && !bm_en));

    assert_wake_full_R3: assert property (@(posedge clk) disable iff (rst)
        (cstate[1] && |bm_req && !pup) |=> (cstate == 2'b00));

    assert_popup_R4: assert property (@(posedge clk) disable iff (rst)
        (cstate[1] && |bm_req && pup && !brk_evt) |=> (cstate == 2'b01 && bm_en));

    assert_pdown_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (cstate == 2'b01 && !pup && !brk_evt) |=> (cstate == 2'b01));

    assert_break_R7: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> (cstate == 2'b00 && bm_en));

    assert_lpc_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (|(bm_req & LPC_MASK)) |=> bm_sts);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (bm_sts && !sts_clr) |=> bm_sts);

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && bm_req == '0) |=> !bm_sts);
endmodule

bind bm_cstate_ctrl bmc_checker #(.NSRC(NSRC), .LPC_MASK(LPC_MASK)) u_chk (
    .clk(clk), .rst(rst), .cfg_rd_data(cfg_rd_data), .sleep_req(sleep_req),
    .brk_evt(brk_evt), .bm_req(bm_req), .sts_clr(sts_clr), .cstate(cstate),
    .bm_en(bm_en), .bm_sts(bm_sts)
);

// File: tb/bm_cstate_ctrl_tb.sv
module bm_cstate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic       sleep_req = 1'b0, sleep_to_c4 = 1'b0, brk_evt = 1'b0, sts_clr = 1'b0;
    logic [3:0] bm_req = '0;
    logic [1:0] cstate;
    logic       bm_en, bm_sts;
    int nchk = 0, nfail = 0;
    bit done = 0;

    localparam logic [1:0] C0 = 2'b00, C2 = 2'b01, C3 = 2'b10, C4 = 2'b11;

    always #4 clk = ~clk;

    bm_cstate_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .sleep_req(sleep_req), .sleep_to_c4(sleep_to_c4),
        .brk_evt(brk_evt), .bm_req(bm_req), .sts_clr(sts_clr), .cstate(cstate),
        .bm_en(bm_en), .bm_sts(bm_sts)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(logic [7:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v; tick(); cfg_wr_en = 1'b0;
    endtask

    task automatic go_sleep(logic c4);
        sleep_req = 1'b1; sleep_to_c4 = c4; tick(); sleep_req = 1'b0;
    endtask

    task automatic clear_sts();
        sts_clr = 1'b1; tick(); sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg reset", cfg_rd_data, 8'h00);
        chk("R2 reset state", cstate, C0);
        chk("R7 reset bm_en", bm_en, 1);
        chk("R11 reset sts", bm_sts, 0);
    endtask

    task automatic t_cfg();
        wr_cfg(8'hFF);
        chk("R1 reserved bits read zero", cfg_rd_data, 8'h9C);
        wr_cfg(8'h80);
        chk("R1 scratch bit", cfg_rd_data, 8'h80);
        wr_cfg(8'h00);
    endtask

    task automatic t_popup_off();
        go_sleep(1'b0);
        chk("R2 enter C3", cstate, C3);
        chk("R2 bm_en low in C3", bm_en, 0);
        bm_req = 4'b0001; tick(); bm_req = '0;
        chk("R3 wake to C0", cstate, C0);
        chk("R8 PCI sets sts", bm_sts, 1);
        clear_sts();
        chk("R11 write-1 clear", bm_sts, 0);
    endtask

    task automatic t_popup_on();
        wr_cfg(8'h18);
        go_sleep(1'b1);
        chk("R2 enter C4", cstate, C4);
        bm_req = 4'b0010; tick();
        chk("R4 popup to C2", cstate, C2);
        chk("R4 bm_en in C2", bm_en, 1);
        chk("R8 PCIe sets sts", bm_sts, 1);
        tick();
        chk("R5 hold C2 while pending", cstate, C2);
        bm_req = '0; tick();
        chk("R5 popdown to C4", cstate, C4);
        chk("R5 bm_en low after popdown", bm_en, 0);
        brk_evt = 1'b1; tick(); brk_evt = 1'b0;
        chk("R7 break from C4", cstate, C0);
        clear_sts();
    endtask

    task automatic t_pdown_gated();
        wr_cfg(8'h18);
        go_sleep(1'b0);
        bm_req = 4'b0100; tick();
        chk("R4 popup from C3", cstate, C2);
        cfg_wr_en = 1'b1; cfg_wr_data = 8'h10; tick(); cfg_wr_en = 1'b0;
        bm_req = '0; tick();
        chk("R6 popdown inert without popup", cstate, C2);
        tick();
        chk("R6 still in C2", cstate, C2);
        brk_evt = 1'b1; bm_req = 4'b0001; tick(); brk_evt = 1'b0; bm_req = '0;
        chk("R7 break from C2", cstate, C0);
        chk("R7 bm_en after break", bm_en, 1);
        clear_sts();
    endtask

    task automatic t_break_prio();
        wr_cfg(8'h18);
        go_sleep(1'b1);
        brk_evt = 1'b1; bm_req = 4'b0001; tick(); brk_evt = 1'b0; bm_req = '0;
        chk("R7 break wins over request", cstate, C0);
        go_sleep(1'b0);
        chk("R2 re-enter C3", cstate, C3);
        brk_evt = 1'b1; tick(); brk_evt = 1'b0;
        chk("R7 break from C3", cstate, C0);
        clear_sts();
        wr_cfg(8'h00);
    endtask

    task automatic t_suppress();
        wr_cfg(8'h04);
        clear_sts();
        bm_req = 4'b0001; tick();
        bm_req = 4'b0010; tick();
        bm_req = 4'b0100; tick(); bm_req = '0;
        chk("R9 suppressed sources", bm_sts, 0);
        bm_req = 4'b1000; tick(); bm_req = '0;
        chk("R9 LPC still sets", bm_sts, 1);
        clear_sts();
        wr_cfg(8'h00);
        bm_req = 4'b0100; tick(); bm_req = '0;
        chk("R8 internal sets", bm_sts, 1);
        wr_cfg(8'h04);
        chk("R10 suppress keeps set flag", bm_sts, 1);
        tick();
        chk("R10 flag still set", bm_sts, 1);
        sts_clr = 1'b1; bm_req = 4'b1000; tick(); sts_clr = 1'b0; bm_req = '0;
        chk("R11 set beats clear", bm_sts, 1);
        clear_sts();
        chk("R11 clear after", bm_sts, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_cfg();
        t_popup_off();
        t_popup_on();
        t_pdown_gated();
        t_break_prio();
        t_suppress();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule